// File: doc/BRIEF.md
# Configuration Access Address Translator

This block turns one configuration-space request (bus, device, function, register offset, read or write) into a short series of accesses on a single local bus. Every accepted request that passes the topology check first writes the configuration type into the outbound translation region. Requests to bus 0 then go straight to the root port's own register window. Requests to any other bus first load the region's target register with the bus/device/function, and then access a fixed remote window.

The block accepts one request at a time. Each local-bus access is a request/acknowledge pair, and the next access starts only after the previous one has been acknowledged. The block gives one response pulse per request. That response carries read data, or an error flag for a write that was rejected.

Top module: `cfg_addr_xlat`

## Requirements
- R1: Only these devices are valid on the two lowest buses: devices 0 and 1 on bus 0, and device 0 on bus 1. Every device on buses 2 and above is valid.
- R2: A read that breaks R1 makes no local-bus access. Its response has `rsp_err`=0 and data 0xFFFFFFFF.
- R3: A write that breaks R1 makes no local-bus access. Its response has `rsp_err`=1.
- R4: The first access of every valid request writes the type code to `TYPE_ADDR` (`ROOT_BASE`+0x904). The code is 4 for buses 0 and 1 and 5 for buses 2 and above, in bits 2:0 with all other bits zero.
- R5: A valid request to bus 0 does not write the target register. Its second access is the data access at `ROOT_BASE` plus the aligned offset.
- R6: A valid request to bus 1 or above makes exactly three accesses: the type write, then a target write, then the data access. The target write goes to `TGT_ADDR` (`ROOT_BASE`+0x918) with value bus<<24 | device<<19 | function<<16. The data access is at `AREA_BASE`+0x00F00000 plus the aligned offset.
- R7: The data access address always has bits 1:0 at zero, whatever the low bits of the request offset.
- R8: For a valid read, the response carries `lb_rdata` from the data access. If `lb_err` comes with that acknowledge, the response carries 0xFFFFFFFF instead.
- R9: A local-bus access holds `lb_req`, `lb_addr`, `lb_we` and `lb_wdata` steady until `lb_ack`. `req_ready` is high only while no request is in progress, and no local-bus access happens at that time.
- R10: The data access of a write has `lb_we`=1 and carries `req_wdata`. The data access of a read has `lb_we`=0. For a valid request, `rsp_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when req_ready is high |
| req_ready | output | 1 | Idle, able to take a request |
| req_we | input | 1 | 1 = configuration write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_reg | input | REG_W | Register byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Rejected write |
| rsp_rdata | output | 32 | Read data |
| lb_req | output | 1 | Local-bus access request |
| lb_we | output | 1 | Local-bus write |
| lb_addr | output | 32 | Local-bus address |
| lb_wdata | output | 32 | Local-bus write data |
| lb_ack | input | 1 | Access complete |
| lb_err | input | 1 | Access aborted (valid with lb_ack) |
| lb_rdata | input | 32 | Read data (valid with lb_ack) |

## Verification
The hardest case to reach from the ports is an abort on the data access of a valid read, because it has to line up with the third acknowledge of the sequence and not the first two. The bench's local-bus model knows the two region register addresses. It raises an error only on read acknowledges to other addresses, at random, and it uses random acknowledge latency so that the stability of held accesses is exercised. Random bus numbers are skewed toward 0, 1 and 2 so that the rejection edges (device 1 versus 2 on bus 0, device 0 versus 1 on bus 1) and the type 0/1 boundary come up often.

// File: rtl/cfg_addr_xlat.sv
module cfg_addr_xlat #(
  parameter int          REG_W     = 12,
  parameter logic [31:0] ROOT_BASE = 32'h01FF_C000,
  parameter logic [31:0] AREA_BASE = 32'h0100_0000,
  parameter logic [31:0] WIN_OFS   = 32'h00F0_0000,
  parameter logic [31:0] TYPE_OFS  = 32'h0000_0904,
  parameter logic [31:0] TGT_OFS   = 32'h0000_0918
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_we,
  input  logic [7:0]       req_bus,
  input  logic [4:0]       req_dev,
  input  logic [2:0]       req_func,
  input  logic [REG_W-1:0] req_reg,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [31:0]      rsp_rdata,
  output logic             lb_req,
  output logic             lb_we,
  output logic [31:0]      lb_addr,
  output logic [31:0]      lb_wdata,
  input  logic             lb_ack,
  input  logic             lb_err,
  input  logic [31:0]      lb_rdata
);
  localparam logic [31:0] TYPE_ADDR = ROOT_BASE + TYPE_OFS;
  localparam logic [31:0] TGT_ADDR  = ROOT_BASE + TGT_OFS;
  localparam logic [31:0] WIN_ADDR  = AREA_BASE + WIN_OFS;
  localparam logic [2:0]  CODE_T0   = 3'd4;
  localparam logic [2:0]  CODE_T1   = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_TYPE, S_TGT, S_DATA, S_RESP} st_t;
  st_t st;

  logic             we_q;
  logic [7:0]       bus_q;
  logic [4:0]       dev_q;
  logic [2:0]       fn_q;
  logic [REG_W-1:0] reg_q;
  logic [31:0]      wd_q;
  logic [31:0]      rd_q;
  logic             err_q;

  wire reject = (req_bus == 8'd0 && req_dev > 5'd1) ||
                (req_bus == 8'd1 && req_dev != 5'd0);
  wire [31:0] aligned = 32'({reg_q[REG_W-1:2], 2'b00});
  wire [31:0] data_addr = ((bus_q == 8'd0) ? ROOT_BASE : WIN_ADDR) + aligned;

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RESP);
  assign rsp_err   = rsp_valid & err_q;
  assign rsp_rdata = rd_q;
  assign lb_req    = (st == S_TYPE) || (st == S_TGT) || (st == S_DATA);

  always_comb begin
    lb_we    = 1'b1;
    lb_addr  = TYPE_ADDR;
    lb_wdata = {29'd0, (bus_q < 8'd2) ? CODE_T0 : CODE_T1};
    if (st == S_TGT) begin
      lb_addr  = TGT_ADDR;
      lb_wdata = {bus_q, dev_q, fn_q, 16'h0000};
    end else if (st == S_DATA) begin
      lb_we    = we_q;
      lb_addr  = data_addr;
      lb_wdata = we_q ? wd_q : 32'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      we_q  <= 1'b0;
      bus_q <= '0;
      dev_q <= '0;
      fn_q  <= '0;
      reg_q <= '0;
      wd_q  <= '0;
      rd_q  <= '0;
      err_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          we_q  <= req_we;
          bus_q <= req_bus;
          dev_q <= req_dev;
          fn_q  <= req_func;
          reg_q <= req_reg;
          wd_q  <= req_wdata;
          if (reject) begin
            rd_q  <= 32'hFFFF_FFFF;
            err_q <= req_we;
            st    <= S_RESP;
          end else begin
            err_q <= 1'b0;
            st    <= S_TYPE;
          end
        end
        S_TYPE: if (lb_ack) st <= (bus_q == 8'd0) ? S_DATA : S_TGT;
        S_TGT:  if (lb_ack) st <= S_DATA;
        S_DATA: if (lb_ack) begin
          rd_q <= (lb_err || we_q) ? 32'hFFFF_FFFF : lb_rdata;
          st   <= S_RESP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_xlat_chk.sv
module cfg_xlat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [31:0] rsp_rdata,
  input logic        lb_req,
  input logic        lb_we,
  input logic [31:0] lb_addr,
  input logic [31:0] lb_wdata,
  input logic        lb_ack,
  input logic        lb_err,
  input logic [31:0] type_addr
);
  // R9
  held_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lb_req && !lb_ack |=> lb_req && $stable(lb_addr) && $stable(lb_we) && $stable(lb_wdata));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !lb_req);

  // R3
  reject_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !$past(lb_req));

  // R8
  abort_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && $past(lb_req && lb_ack && lb_err && !lb_we) |-> rsp_rdata == 32'hFFFF_FFFF);

  // R4
  type_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lb_req && lb_addr == type_addr |-> lb_we && (lb_wdata == 32'd4 || lb_wdata == 32'd5));

  // R7
  data_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lb_req |-> lb_addr[1:0] == 2'b00);
endmodule

bind cfg_addr_xlat cfg_xlat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .lb_req(lb_req), .lb_we(lb_we),
  .lb_addr(lb_addr), .lb_wdata(lb_wdata), .lb_ack(lb_ack), .lb_err(lb_err),
  .type_addr(TYPE_ADDR)
);

// File: tb/sim_cfg_addr_xlat.sv
module sim_cfg_addr_xlat;
  localparam logic [31:0] ROOT = 32'h01FF_C000;
  localparam logic [31:0] TYPA = ROOT + 32'h904;
  localparam logic [31:0] TGTA = ROOT + 32'h918;
  localparam logic [31:0] WIN  = 32'h0100_0000 + 32'h00F0_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [7:0] req_bus = '0;
  logic [4:0] req_dev = '0;
  logic [2:0] req_func = '0;
  logic [11:0] req_reg = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic lb_req, lb_we;
  logic [31:0] lb_addr, lb_wdata;
  logic lb_ack = 1'b0, lb_err = 1'b0;
  logic [31:0] lb_rdata = '0;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  logic [31:0] log_addr [4];
  logic        log_we   [4];
  logic [31:0] log_wd   [4];
  int          n_log = 0;
  bit          last_err = 1'b0;
  int          lat = 0;
  int          err_pct = 0;

  always #10 clk = ~clk;

  cfg_addr_xlat u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
    .req_reg(req_reg), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .lb_req(lb_req), .lb_we(lb_we),
    .lb_addr(lb_addr), .lb_wdata(lb_wdata), .lb_ack(lb_ack), .lb_err(lb_err),
    .lb_rdata(lb_rdata)
  );

  function automatic logic [31:0] model_data(input logic [31:0] a);
    return a ^ 32'hA5A5_0F0F;
  endfunction

  function automatic bit rejected(input logic [7:0] b, input logic [4:0] d);
    return (b == 8'd0 && d > 5'd1) || (b == 8'd1 && d != 5'd0);
  endfunction

  // local-bus model: random latency, abort only on data reads
  always @(negedge clk) begin
    lb_ack <= 1'b0;
    lb_err <= 1'b0;
    if (rst_n && lb_req && !lb_ack) begin
      if (lat > 0) lat <= lat - 1;
      else begin
        lb_ack <= 1'b1;
        if (n_log < 4) begin
          log_addr[n_log] = lb_addr;
          log_we[n_log]   = lb_we;
          log_wd[n_log]   = lb_wdata;
        end
        n_log = n_log + 1;
        last_err = 1'b0;
        if (!lb_we && lb_addr != TYPA && lb_addr != TGTA &&
            int'($urandom_range(99)) < err_pct) begin
          lb_err <= 1'b1;
          last_err = 1'b1;
        end
        lb_rdata <= model_data(lb_addr);
        lat <= int'($urandom_range(4));
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input bit we, input logic [7:0] b, input logic [4:0] d,
                     input logic [2:0] f, input logic [11:0] r, input logic [31:0] wd);
    logic [31:0] base, daddr;
    int k;
    while (!req_ready) @(negedge clk);
    n_log = 0;
    req_valid = 1'b1; req_we = we; req_bus = b; req_dev = d;
    req_func = f; req_reg = r; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    if (rejected(b, d)) begin
      check("R1 access count on rejected request", 32'(n_log), 32'd0);
      if (we) check("R3 rejected write error flag", 32'(rsp_err), 32'd1);
      else begin
        check("R2 rejected read error flag", 32'(rsp_err), 32'd0);
        check("R2 rejected read data", rsp_rdata, 32'hFFFF_FFFF);
      end
    end else begin
      check("R10 valid request error flag", 32'(rsp_err), 32'd0);
      check("R1 R5 R6 access count", 32'(n_log), (b == 0) ? 32'd2 : 32'd3);
      check("R4 type access address", log_addr[0], TYPA);
      check("R4 type access value", log_wd[0], (b < 2) ? 32'd4 : 32'd5);
      check("R4 type access write", 32'(log_we[0]), 32'd1);
      if (b != 0) begin
        check("R6 target address", log_addr[1], TGTA);
        check("R6 target value", log_wd[1], {b, d, f, 16'h0});
        k = 2;
      end else k = 1;
      base  = (b == 0) ? ROOT : WIN;
      daddr = base + {20'd0, r[11:2], 2'b00};
      check("R5 R6 R7 data address", log_addr[k], daddr);
      check("R10 data direction", 32'(log_we[k]), 32'(we));
      if (we) check("R10 write data", log_wd[k], wd);
      else check("R8 read data", rsp_rdata, last_err ? 32'hFFFF_FFFF : model_data(daddr));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R9 reset ready", 32'(req_ready), 32'd1);
    check("R9 reset no access", 32'(lb_req), 32'd0);
    check("R9 reset no response", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run(1'b0, 8'd0, 5'd1, 3'd0, 12'h00B, 32'h0);
    run(1'b0, 8'd0, 5'd2, 3'd0, 12'h010, 32'h0);
    run(1'b1, 8'd0, 5'd2, 3'd0, 12'h010, 32'h1234_5678);
    run(1'b1, 8'd0, 5'd0, 3'd0, 12'h007, 32'hCAFE_0001);
    run(1'b0, 8'd1, 5'd0, 3'd7, 12'hFFF, 32'h0);
    run(1'b0, 8'd1, 5'd1, 3'd0, 12'h000, 32'h0);
    run(1'b1, 8'd1, 5'd31, 3'd0, 12'h000, 32'h5);
    run(1'b1, 8'd2, 5'd31, 3'd7, 12'h102, 32'hDEAD_BEEF);
    run(1'b0, 8'd255, 5'd17, 3'd3, 12'h3FD, 32'h0);
    err_pct = 100;
    run(1'b0, 8'd5, 5'd4, 3'd1, 12'h040, 32'h0);
    run(1'b0, 8'd0, 5'd0, 3'd0, 12'h044, 32'h0);
    err_pct = 25;
    for (int i = 0; i < 400; i++) begin
      logic [7:0] b;
      int sel = int'($urandom_range(9));
      b = (sel < 3) ? 8'd0 : (sel < 6) ? 8'd1 : (sel < 8) ? 8'd2 : 8'($urandom_range(255));
      run(1'($urandom_range(1)), b, 5'((sel < 6) ? $urandom_range(3) : $urandom_range(31)),
          3'($urandom_range(7)), 12'($urandom_range(4095)), $urandom());
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule